// File: doc/BRIEF.md
# Tagged Add/Subtract Trap Unit

This block adds or subtracts two tagged integers and decides whether the operation may retire. A tagged integer keeps a small type tag in its least significant bits. Both operands of an arithmetic step are expected to carry a tag of zero. If either operand carries a nonzero tag, or if the signed arithmetic overflows, the operation is refused. The block then raises a one-cycle trap strobe and leaves its result and condition-code registers exactly as they were.

When the operation is accepted, the block loads the new result and the four condition flags: negative, zero, overflow and carry. It also pulses a flag-write enable for one cycle, so a downstream status register can capture the flags. Overflow always reads as clear on an accepted operation, because any signed overflow would have trapped. The outputs are registered and appear one cycle after the valid strobe. The data width, the tag width and the adder structure are parameters.

Top module: `tag_trap_alu`

## Requirements
- R1: While reset is asserted and after it is released, before any valid strobe, every output is zero.
- R2: One cycle after a valid strobe that does not trap, out_result equals in_a + in_b modulo 2^DATA_W when in_sub is 0, or in_a - in_b modulo 2^DATA_W when in_sub is 1, and out_flag_we is 1 for exactly that cycle.
- R3: A valid strobe where bits [TAG_W-1:0] of in_a OR in_b are nonzero makes out_trap 1 one cycle later (TAG_W=2 means bits 1 and 0).
- R4: A valid addition traps when bit DATA_W-1 of ~(in_a ^ in_b) & (in_a ^ sum) is 1.
- R5: A valid subtraction traps when bit DATA_W-1 of (in_a ^ in_b) & (in_a ^ difference) is 1.
- R6: In the cycle where out_trap is 1, out_result and all four flags hold the values they had in the cycle before.
- R7: After an accepted operation, out_n is bit DATA_W-1 of the result, out_z is 1 exactly when the result is zero, and out_v is 0.
- R8: After an accepted operation, out_c is 1 for an addition when the unsigned result is less than in_a, and for a subtraction when in_a is less than in_b as unsigned numbers.
- R9: One cycle after a cycle with in_valid low, out_trap and out_flag_we are both 0 and the result and flags are unchanged.
- R10: out_trap and out_flag_we are never 1 in the same cycle, and each valid strobe produces exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_sub | input | 1 | 0 selects addition, 1 selects subtraction |
| in_a | input | DATA_W | First tagged operand |
| in_b | input | DATA_W | Second tagged operand |
| out_result | output | DATA_W | Last accepted result |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry / borrow flag |
| out_flag_we | output | 1 | One-cycle pulse: operation accepted, flags written |
| out_trap | output | 1 | One-cycle pulse: operation refused |

## Verification
All state lives in the output registers, so a wrong load decision shows at the ports one cycle after the strobe: a trapped operation that still changed the result or flags, or an accepted one that did not. The next accepted operation then overwrites the state, so a corrupted hold persists only until that operation and must be seen in that window. An 8-bit instance is swept over every first operand and a spread of second operands covering each tag pattern, in both modes, with idle gaps mixed in. Every cycle is compared against an arithmetic model that carries its own copy of the held state.

// File: rtl/tag_alu_pkg.sv
package tag_alu_pkg;

   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } cc_t;

   localparam cc_t CC_CLEAR = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

endpackage

// File: rtl/tag_check.sv
module tag_check #(
   parameter int TAG_W = 2
) (
   input  logic [TAG_W-1:0] tag_a,
   input  logic [TAG_W-1:0] tag_b,
   output logic             tag_hit
);

   logic [TAG_W-1:0] tag_or;

   generate
      for (genvar i = 0; i < TAG_W; i++) begin : g_or
         assign tag_or[i] = tag_a[i] | tag_b[i];
      end
   endgenerate

   assign tag_hit = |tag_or;

endmodule

// File: rtl/tag_addsub.sv
module tag_addsub
   import tag_alu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit RIPPLE_ADDER = 1'b0
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  op_e               op,
   output logic [DATA_W-1:0] sum,
   output logic              carry_flag,
   output logic              ovf
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] opb_eff;
   logic              cin;
   logic              cout;
   logic [DATA_W-1:0] diff_ab;
   logic [DATA_W-1:0] diff_as;
   logic [DATA_W-1:0] ovf_add_vec;
   logic [DATA_W-1:0] ovf_sub_vec;

   assign cin     = (op == OP_SUB);
   assign opb_eff = cin ? ~opb : opb;

   generate
      if (RIPPLE_ADDER) begin : g_ripple
         logic [DATA_W:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]     = opa[i] ^ opb_eff[i] ^ chain[i];
            assign chain[i+1] = (opa[i] & opb_eff[i]) | (chain[i] & (opa[i] ^ opb_eff[i]));
         end
         assign cout = chain[DATA_W];
      end else begin : g_native
         logic [DATA_W:0] wide;
         assign wide = {1'b0, opa} + {1'b0, opb_eff} + {{DATA_W{1'b0}}, cin};
         assign sum  = wide[DATA_W-1:0];
         assign cout = wide[DATA_W];
      end
   endgenerate

   // add: carry out means result wrapped below opa; sub: no carry out means borrow
   assign carry_flag = cin ? ~cout : cout;

   assign diff_ab     = opa ^ opb;
   assign diff_as     = opa ^ sum;
   assign ovf_add_vec = ~diff_ab & diff_as;
   assign ovf_sub_vec = diff_ab & diff_as;
   assign ovf         = cin ? ovf_sub_vec[MSB] : ovf_add_vec[MSB];

endmodule

// File: rtl/tag_cc_gen.sv
module tag_cc_gen
   import tag_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] res,
   input  logic              carry_flag,
   output cc_t               cc
);

   always_comb begin
      cc   = CC_CLEAR;
      cc.n = res[DATA_W-1];
      cc.z = (res == '0);
      cc.v = 1'b0;
      cc.c = carry_flag;
   end

endmodule

// File: rtl/tag_trap_alu.sv
module tag_trap_alu
   import tag_alu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int TAG_W        = 2,
   parameter bit RIPPLE_ADDER = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sub,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   output logic [DATA_W-1:0] out_result,
   output logic              out_n,
   output logic              out_z,
   output logic              out_v,
   output logic              out_c,
   output logic              out_flag_we,
   output logic              out_trap
);

   initial begin
      assert (TAG_W >= 1) else $error("tag_trap_alu: TAG_W must be at least 1");
      assert (DATA_W > TAG_W + 1) else $error("tag_trap_alu: DATA_W too small for TAG_W");
   end

   logic [DATA_W-1:0] sum;
   logic              carry_flag;
   logic              arith_ovf;
   logic              tag_hit;
   logic              trap_now;
   cc_t               cc_next;
   cc_t               cc_q;
   op_e               op;

   assign op = op_e'(in_sub);

   tag_check #(.TAG_W(TAG_W)) u_tag (
      .tag_a   (in_a[TAG_W-1:0]),
      .tag_b   (in_b[TAG_W-1:0]),
      .tag_hit (tag_hit)
   );

   tag_addsub #(.DATA_W(DATA_W), .RIPPLE_ADDER(RIPPLE_ADDER)) u_arith (
      .opa        (in_a),
      .opb        (in_b),
      .op         (op),
      .sum        (sum),
      .carry_flag (carry_flag),
      .ovf        (arith_ovf)
   );

   tag_cc_gen #(.DATA_W(DATA_W)) u_cc (
      .res        (sum),
      .carry_flag (carry_flag),
      .cc         (cc_next)
   );

   assign trap_now = tag_hit | arith_ovf;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_result  <= '0;
         cc_q        <= CC_CLEAR;
         out_flag_we <= 1'b0;
         out_trap    <= 1'b0;
      end else begin
         out_flag_we <= 1'b0;
         out_trap    <= 1'b0;
         if (in_valid) begin
            if (trap_now) begin
               out_trap <= 1'b1;
            end else begin
               out_result  <= sum;
               cc_q        <= cc_next;
               out_flag_we <= 1'b1;
            end
         end
      end
   end

   assign out_n = cc_q.n;
   assign out_z = cc_q.z;
   assign out_v = cc_q.v;
   assign out_c = cc_q.c;

endmodule

// File: rtl/tag_trap_alu_chk.sv
module tag_trap_alu_chk #(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [TAG_W-1:0]  tag_bits,
   input logic [DATA_W-1:0] out_result,
   input logic              out_n,
   input logic              out_z,
   input logic              out_v,
   input logic              out_c,
   input logic              out_flag_we,
   input logic              out_trap
);

   assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_trap && out_flag_we));

   assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid) |-> (out_trap || out_flag_we));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> (!out_trap && !out_flag_we));

   assert_trap_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_trap |-> ($stable(out_result) && $stable({out_n, out_z, out_v, out_c})));

   assert_tag_traps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && ($past(tag_bits) != '0)) |-> out_trap);

   assert_flags_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_flag_we |-> ((out_z == (out_result == '0)) && (out_n == out_result[DATA_W-1]) && !out_v));

endmodule

bind tag_trap_alu tag_trap_alu_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .tag_bits    (in_a[TAG_W-1:0] | in_b[TAG_W-1:0]),
   .out_result  (out_result),
   .out_n       (out_n),
   .out_z       (out_z),
   .out_v       (out_v),
   .out_c       (out_c),
   .out_flag_we (out_flag_we),
   .out_trap    (out_trap)
);

// File: tb/tag_trap_alu_tb.sv
`timescale 1ns/1ps
module tag_trap_alu_tb;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_sub = 1'b0;
   logic [W-1:0] in_a = '0;
   logic [W-1:0] in_b = '0;
   logic [W-1:0] out_result;
   logic         out_n, out_z, out_v, out_c, out_flag_we, out_trap;

   int checks = 0;
   int fails  = 0;

   // model state
   logic [W-1:0] m_res = '0;
   logic         m_n = 1'b0, m_z = 1'b0, m_v = 1'b0, m_c = 1'b0;
   logic         m_we = 1'b0, m_trap = 1'b0;
   string        m_why = "R9";

   always #10 clk = ~clk;

   tag_trap_alu #(.DATA_W(W), .TAG_W(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
      .in_a(in_a), .in_b(in_b), .out_result(out_result),
      .out_n(out_n), .out_z(out_z), .out_v(out_v), .out_c(out_c),
      .out_flag_we(out_flag_we), .out_trap(out_trap)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic verify();
      string rl, fl;
      rl = m_trap ? "R6" : (m_we ? "R2" : "R9");
      fl = m_trap ? "R6" : (m_we ? "R7" : "R9");
      chk(out_trap == m_trap, {m_why, " trap"}, int'(out_trap), int'(m_trap));
      chk(out_flag_we == m_we, {m_why, " flag_we"}, int'(out_flag_we), int'(m_we));
      chk(!(out_trap && out_flag_we), "R10 exclusive", int'({out_trap, out_flag_we}), 0);
      chk(out_result == m_res, {rl, " result"}, int'(out_result), int'(m_res));
      chk({out_n, out_z, out_v} == {m_n, m_z, m_v}, {fl, " nzv"},
          int'({out_n, out_z, out_v}), int'({m_n, m_z, m_v}));
      chk(out_c == m_c, m_we ? "R8 carry" : {fl, " carry"}, int'(out_c), int'(m_c));
   endtask

   task automatic apply(input bit v, input bit s, input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] r;
      logic [W-1:0] ovec;
      bit tag, ovf;
      @(negedge clk);
      verify();
      in_valid = v; in_sub = s; in_a = a; in_b = b;
      m_we = 1'b0; m_trap = 1'b0;
      if (!v) begin
         m_why = "R9";
      end else begin
         r    = s ? a - b : a + b;
         ovec = s ? ((a ^ b) & (a ^ r)) : (~(a ^ b) & (a ^ r));
         ovf  = ovec[W-1];
         tag  = ((a | b) & 8'h03) != 0;
         if (tag) begin
            m_trap = 1'b1; m_why = "R3";
         end else if (ovf) begin
            m_trap = 1'b1; m_why = s ? "R5" : "R4";
         end else begin
            m_we  = 1'b1; m_why = "R2";
            m_res = r;
            m_n   = r[W-1];
            m_z   = (r == 0);
            m_v   = 1'b0;
            m_c   = s ? (a < b) : (r < a);
         end
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : stim
      int n;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk({out_result, out_n, out_z, out_v, out_c, out_flag_we, out_trap} == '0,
          "R1 reset", int'({out_result, out_n, out_z, out_v, out_c, out_flag_we, out_trap}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({out_result, out_n, out_z, out_v, out_c, out_flag_we, out_trap} == '0,
          "R1 after release", int'({out_result, out_n, out_z, out_v, out_c, out_flag_we, out_trap}), 0);

      // directed boundaries
      apply(1, 0, 8'h7C, 8'h04);  // R4 add overflow to 0x80
      apply(1, 0, 8'h7C, 8'h00);  // accepted, positive
      apply(1, 1, 8'h80, 8'h04);  // R5 sub overflow
      apply(1, 0, 8'hFC, 8'h04);  // zero with carry, R7 R8
      apply(1, 1, 8'h04, 8'h08);  // borrow R8
      apply(1, 0, 8'h05, 8'h04);  // tag R3, R6 hold
      apply(0, 0, 8'h10, 8'h10);  // idle R9
      apply(1, 1, 8'h10, 8'h10);  // zero difference, no borrow

      // near-exhaustive sweep in both modes
      n = 0;
      for (int s = 0; s < 2; s++) begin
         for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 3) begin
               n++;
               if (n % 7 == 0) apply(0, 1'(s), 8'(b), 8'(a));
               apply(1, 1'(s), 8'(a), 8'(b));
            end
         end
      end
      apply(0, 0, 8'h00, 8'h00);
      apply(0, 0, 8'h00, 8'h00);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule